// File: doc/BRIEF.md
# Integer ALU with Carry, Overflow and Condition Flags

This block is a registered integer unit. It takes two operands and a 3-bit operation code, and produces a sum, a sum with carry-in, or a bitwise AND, OR, XOR or NOT. A small status register holds three bits: carry, overflow and a sticky summary overflow. A condition register holds a 4-bit zero-compare field. Three per-operation enables choose what an operation may change:
- `ca_en_i` lets it change the carry bit.
- `oe_en_i` lets it change the overflow bits.
- `rc_en_i` lets it write the condition field.

The arithmetic is done one bit wider than the data path. Carry and signed overflow both come from that extra bit. The logical operations cannot produce a carry or an overflow. A separate write port loads the status register directly. That port is the only way, other than reset, to clear the sticky summary bit.

All updates happen on the rising clock edge when `valid_i` is high. Results are visible on the outputs in the cycle after that edge.

Top module: `int_alu_flags`

## Requirements
- R1: Synchronous active-high reset clears the result, CA, OV, SO and the whole condition register to zero.
- R2: Operation codes are 0 ADD (a+b), 1 ADDC (a+b+current CA), 2 AND, 3 OR, 4 XOR and 5 NOT (~a, b ignored). Each result is taken modulo 2^W.
- R3: When `ca_en_i` is high, CA takes the carry-out of the unsigned widened sum. When it is low, CA keeps its value.
- R4: When `oe_en_i` is high, OV takes the signed-overflow flag, and an overflow also sets SO. When no overflow occurs, SO is left unchanged (sticky). When `oe_en_i` is low, OV and SO both hold.
- R5: Logical operations (AND, OR, XOR, NOT) produce no carry and no overflow. With the enables high, they clear CA and OV.
- R6: When `rc_en_i` is high, condition field 0 takes one of LT, GT or EQ from a signed compare of the result with zero, plus SO.
  - The field sits in bits [31:28] of `cr_o`: LT at 31, GT at 30, EQ at 29, SO at 28.
  - The SO value used is the one after this operation's overflow update.
  - Bits [27:0] are never written and stay zero.
- R7: When `rc_en_i` is low, the condition register is unchanged.
- R8: Operation codes 6 and 7, and cycles with `valid_i` low, change no state.
- R9: When `xer_wr_i` is high, the status register loads `xer_wdata_i` as bit 2 SO, bit 1 OV and bit 0 CA. This write wins over the status update of an operation in the same cycle. That operation's result and condition field are still written.
- R10: Every update lands on a rising edge and is visible on the outputs from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| ca_en_i | input | 1 | Allow carry update |
| oe_en_i | input | 1 | Allow overflow update |
| rc_en_i | input | 1 | Allow condition field 0 update |
| xer_wr_i | input | 1 | Direct status register write |
| xer_wdata_i | input | 3 | Write data {SO, OV, CA} |
| result_o | output | W | Registered result |
| ca_o | output | 1 | Carry bit |
| ov_o | output | 1 | Overflow bit |
| so_o | output | 1 | Sticky summary overflow bit |
| cr_o | output | 32 | Condition register |

## Verification
The bench builds the block with its default 32-bit data width. At that width the signed boundaries 0x7FFFFFFF and 0x80000000 and the all-ones carry case can be driven directly.

Directed scenarios cover:
- positive and negative overflow;
- carry chains through ADDC;
- the sticky summary bit surviving a later clean addition;
- a status write that collides with an overflowing operation in the same cycle.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int CR_WIDTH = 32;
    localparam int CR_FLD_W = 4;
    localparam int CR_NFLD  = CR_WIDTH / CR_FLD_W;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_NOT  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    // Status bits, MSB first: summary overflow, overflow, carry
    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } stat_t;

    // Zero-compare field, MSB first
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crfld_t;

    function automatic logic op_legal(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_AND) ||
               (op == OP_OR)  || (op == OP_XOR)  || (op == OP_NOT);
    endfunction

    function automatic logic op_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC);
    endfunction

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           carry,
    output logic           ovf
);
    localparam int WX = W + 1;

    logic [WX-1:0] u_wide;
    logic [WX-1:0] s_wide;
    logic [WX-1:0] cin_x;
    logic [W-1:0]  lres;

    always_comb begin
        cin_x = '0;
        cin_x[0] = (op == OP_ADDC) ? cin : 1'b0;
    end

    always_comb begin
        unique case (op)
            OP_AND:  lres = a & b;
            OP_OR:   lres = a | b;
            OP_XOR:  lres = a ^ b;
            OP_NOT:  lres = ~a;
            default: lres = '0;
        endcase
    end

    always_comb begin
        if (op_arith(op)) begin
            u_wide = {1'b0, a} + {1'b0, b} + cin_x;
            s_wide = {a[W-1], a} + {b[W-1], b} + cin_x;
        end else begin
            u_wide = {1'b0, lres};
            s_wide = {lres[W-1], lres};
        end
    end

    assign res   = u_wide[W-1:0];
    assign carry = u_wide[W];
    assign ovf   = s_wide[W] ^ s_wide[W-1];

endmodule

// File: rtl/alu_status.sv
module alu_status
    import alu_pkg::*;
(
    input  stat_t        cur,
    input  logic         fire,
    input  logic         ca_en,
    input  logic         oe_en,
    input  logic         carry,
    input  logic         ovf,
    input  logic         wr,
    input  logic [2:0]   wdata,
    output stat_t        nxt,
    output logic         so_after_op
);
    stat_t op_nxt;

    always_comb begin
        op_nxt = cur;
        if (fire && ca_en) begin
            op_nxt.ca = carry;
        end
        if (fire && oe_en) begin
            op_nxt.ov = ovf;
            if (ovf) begin
                op_nxt.so = 1'b1;
            end
        end
    end

    assign so_after_op = op_nxt.so;
    assign nxt         = wr ? stat_t'(wdata) : op_nxt;

endmodule

// File: rtl/alu_cond.sv
module alu_cond
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic         so,
    output crfld_t       fld
);
    always_comb begin
        fld.lt = res[W-1];
        fld.eq = (res == '0);
        fld.gt = !res[W-1] && (res != '0);
        fld.so = so;
    end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic [2:0]          op_i,
    input  logic [W-1:0]        a_i,
    input  logic [W-1:0]        b_i,
    input  logic                ca_en_i,
    input  logic                oe_en_i,
    input  logic                rc_en_i,
    input  logic                xer_wr_i,
    input  logic [2:0]          xer_wdata_i,
    output logic [W-1:0]        result_o,
    output logic                ca_o,
    output logic                ov_o,
    output logic                so_o,
    output logic [CR_WIDTH-1:0] cr_o
);
    alu_op_e       op;
    logic          fire;
    logic [W-1:0]  dp_res;
    logic          dp_carry;
    logic          dp_ovf;
    stat_t         stat_q;
    stat_t         stat_d;
    logic          so_for_cr;
    crfld_t        fld0;
    logic [W-1:0]  res_q;
    logic [CR_WIDTH-1:0] cr_q;

    assign op   = alu_op_e'(op_i);
    assign fire = valid_i && op_legal(op);

    alu_datapath #(.W(W)) u_dp (
        .op    (op),
        .a     (a_i),
        .b     (b_i),
        .cin   (stat_q.ca),
        .res   (dp_res),
        .carry (dp_carry),
        .ovf   (dp_ovf)
    );

    alu_status u_stat (
        .cur         (stat_q),
        .fire        (fire),
        .ca_en       (ca_en_i),
        .oe_en       (oe_en_i),
        .carry       (dp_carry),
        .ovf         (dp_ovf),
        .wr          (xer_wr_i),
        .wdata       (xer_wdata_i),
        .nxt         (stat_d),
        .so_after_op (so_for_cr)
    );

    alu_cond #(.W(W)) u_cond (
        .res (dp_res),
        .so  (so_for_cr),
        .fld (fld0)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
            if (fire) begin
                res_q <= dp_res;
            end
        end
    end

    // Field 0 occupies the most significant nibble; the others only hold
    for (genvar f = 0; f < CR_NFLD; f++) begin : g_crfld
        localparam int HI = CR_WIDTH - 1 - f * CR_FLD_W;
        localparam int LO = HI - CR_FLD_W + 1;
        if (f == 0) begin : g_f0
            always_ff @(posedge clk) begin
                if (rst) begin
                    cr_q[HI:LO] <= '0;
                end else if (fire && rc_en_i) begin
                    cr_q[HI:LO] <= fld0;
                end
            end
        end else begin : g_fn
            always_ff @(posedge clk) begin
                if (rst) begin
                    cr_q[HI:LO] <= '0;
                end
            end
        end
    end

    assign result_o = res_q;
    assign ca_o     = stat_q.ca;
    assign ov_o     = stat_q.ov;
    assign so_o     = stat_q.so;
    assign cr_o     = cr_q;

endmodule

// File: rtl/int_alu_flags_chk.sv
module int_alu_flags_chk #(
    parameter int W = 32
) (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [2:0]  op_i,
    input logic        ca_en_i,
    input logic        oe_en_i,
    input logic        rc_en_i,
    input logic        xer_wr_i,
    input logic [W-1:0] result_o,
    input logic        ca_o,
    input logic        ov_o,
    input logic        so_o,
    input logic [31:0] cr_o
);
    logic legal;
    assign legal = (op_i <= 3'd5);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (result_o == '0) && !ca_o && !ov_o && !so_o && (cr_o == '0));

    // R3
    ca_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_i && legal && ca_en_i) && !xer_wr_i |=> $stable(ca_o));

    // R4
    so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        so_o && !xer_wr_i |=> so_o);

    // R4
    ov_sets_so_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i && legal && oe_en_i && !xer_wr_i |=> (!ov_o || so_o));

    // R5
    logic_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i && (op_i >= 3'd2) && legal && ca_en_i && oe_en_i && !xer_wr_i
        |=> !ca_o && !ov_o);

    // R6
    cr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i && legal && rc_en_i |=> ($countones(cr_o[31:29]) == 1));

    // R6
    cr_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cr_o[27:0] == '0);

    // R7
    cr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_i && legal && rc_en_i) |=> $stable(cr_o));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_i && legal) |=> $stable(result_o));
endmodule

bind int_alu_flags int_alu_flags_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .ca_en_i  (ca_en_i),
    .oe_en_i  (oe_en_i),
    .rc_en_i  (rc_en_i),
    .xer_wr_i (xer_wr_i),
    .result_o (result_o),
    .ca_o     (ca_o),
    .ov_o     (ov_o),
    .so_o     (so_o),
    .cr_o     (cr_o)
);

// File: tb/int_alu_flags_tb.sv
module int_alu_flags_tb;
    localparam int W = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [2:0]  op_i;
    logic [W-1:0] a_i;
    logic [W-1:0] b_i;
    logic        ca_en_i;
    logic        oe_en_i;
    logic        rc_en_i;
    logic        xer_wr_i;
    logic [2:0]  xer_wdata_i;
    logic [W-1:0] result_o;
    logic        ca_o;
    logic        ov_o;
    logic        so_o;
    logic [31:0] cr_o;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    int_alu_flags #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .ca_en_i(ca_en_i), .oe_en_i(oe_en_i),
        .rc_en_i(rc_en_i), .xer_wr_i(xer_wr_i), .xer_wdata_i(xer_wdata_i),
        .result_o(result_o), .ca_o(ca_o), .ov_o(ov_o), .so_o(so_o),
        .cr_o(cr_o)
    );

    task automatic chk(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [31:0] r,
                           input logic c, input logic o, input logic s,
                           input logic [31:0] cr);
        chk({tag, " result"}, result_o, r);
        chk({tag, " stat"}, {29'd0, so_o, ov_o, ca_o}, {29'd0, s, o, c});
        chk({tag, " cr"}, cr_o, cr);
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic ce,
                          input logic oe, input logic rc);
        @(negedge clk);
        valid_i = 1'b1; op_i = op; a_i = a; b_i = b;
        ca_en_i = ce; oe_en_i = oe; rc_en_i = rc;
        @(negedge clk);
        valid_i = 1'b0; xer_wr_i = 1'b0;
    endtask

    task automatic xer_write(input logic [2:0] d);
        @(negedge clk);
        xer_wr_i = 1'b1; xer_wdata_i = d;
        @(negedge clk);
        xer_wr_i = 1'b0;
    endtask

    task automatic t_reset;
        chk_all("R1 reset", 32'h0, 1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_add_basic;
        run_op(3'd0, 32'd5, 32'd7, 1, 1, 1);
        chk_all("R2 R6 add", 32'd12, 0, 0, 0, 32'h4000_0000);
    endtask

    task automatic t_carry;
        run_op(3'd0, 32'hFFFF_FFFF, 32'd1, 1, 0, 1);
        chk_all("R3 carry", 32'h0, 1, 0, 0, 32'h2000_0000);
        // R7: rc off, cr holds; ADDC uses CA=1; ca_en off holds CA
        run_op(3'd1, 32'd2, 32'd3, 0, 0, 0);
        chk_all("R2 R7 addc", 32'd6, 1, 0, 0, 32'h2000_0000);
    endtask

    task automatic t_overflow;
        run_op(3'd0, 32'h7FFF_FFFF, 32'd1, 1, 1, 1);
        chk_all("R4 R6 pos ovf", 32'h8000_0000, 0, 1, 1, 32'h9000_0000);
        run_op(3'd0, 32'd1, 32'd1, 0, 1, 1);
        chk_all("R4 sticky", 32'd2, 0, 0, 1, 32'h5000_0000);
        run_op(3'd0, 32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 0);
        chk_all("R3 R4 neg ovf", 32'h7FFF_FFFF, 1, 1, 1, 32'h5000_0000);
    endtask

    task automatic t_logic;
        run_op(3'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, 1, 1, 1);
        chk_all("R5 and", 32'hF000_F000, 0, 0, 1, 32'h9000_0000);
        run_op(3'd3, 32'h0000_0F00, 32'h0000_00F0, 0, 0, 0);
        chk_all("R5 or", 32'h0000_0FF0, 0, 0, 1, 32'h9000_0000);
        run_op(3'd4, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 0, 0, 1);
        chk_all("R5 R6 xor", 32'h0, 0, 0, 1, 32'h3000_0000);
        run_op(3'd5, 32'h0000_FFFF, 32'h1234_5678, 0, 0, 1);
        chk_all("R2 not", 32'hFFFF_0000, 0, 0, 1, 32'h9000_0000);
    endtask

    task automatic t_xer_write;
        xer_write(3'b000);
        chk_all("R9 clear", 32'hFFFF_0000, 0, 0, 0, 32'h9000_0000);
        // R9 collision: write wins status, cr uses op-derived SO
        @(negedge clk);
        xer_wr_i = 1'b1; xer_wdata_i = 3'b101;
        run_op(3'd0, 32'h7FFF_FFFF, 32'd1, 1, 1, 1);
        chk_all("R9 collide", 32'h8000_0000, 1, 0, 1, 32'h9000_0000);
    endtask

    task automatic t_reserved;
        run_op(3'd6, 32'd1, 32'd1, 1, 1, 1);
        chk_all("R8 op6", 32'h8000_0000, 1, 0, 1, 32'h9000_0000);
        run_op(3'd7, 32'd0, 32'd0, 1, 1, 1);
        chk_all("R8 op7", 32'h8000_0000, 1, 0, 1, 32'h9000_0000);
        @(negedge clk);
        op_i = 3'd0; a_i = 32'd3; b_i = 32'd4;
        ca_en_i = 1; oe_en_i = 1; rc_en_i = 1;
        @(negedge clk);
        chk_all("R8 idle", 32'h8000_0000, 1, 0, 1, 32'h9000_0000);
    endtask

    task automatic t_addc_chain;
        xer_write(3'b001);
        run_op(3'd1, 32'hFFFF_FFFF, 32'd0, 1, 1, 0);
        chk_all("R2 R3 addc chain", 32'h0, 1, 0, 0, 32'h9000_0000);
        run_op(3'd1, 32'h7FFF_FFFF, 32'd0, 1, 1, 1);
        chk_all("R4 addc ovf", 32'h8000_0000, 0, 1, 1, 32'h9000_0000);
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        // R10: visible right after the reset edge
        chk_all("R1 R10 re-reset", 32'h0, 0, 0, 0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; valid_i = 0; op_i = 0; a_i = 0; b_i = 0;
        ca_en_i = 0; oe_en_i = 0; rc_en_i = 0; xer_wr_i = 0; xer_wdata_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_add_basic;
        t_carry;
        t_overflow;
        t_logic;
        t_xer_write;
        t_reserved;
        t_addc_chain;
        t_reset_again;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule